// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block guards a processor against a hung program. A counter advances on an instruction-cycle enable pulse while the watchdog is running. Software must restart it regularly. If it does not, the block first raises a warning flag, and an interrupt request when that interrupt is enabled. A fixed number of ticks later it emits a one-cycle system reset request. A two-bit interval code picks one of four power-of-two warning points. The spacing between those points and the warning-to-reset gap are parameters.

Software reaches the block through a write-only register bus with three addresses: unlock (0), control (1) and configuration (2). The restart, run and warning-flag bits of the control register are guarded. A write to them counts only when it comes straight after a write of AAh and then 55h to the unlock address, and only while a short window after the second key byte is still open. A sticky flag records that the last reset came from the watchdog. This flag survives the watchdog's own reset request and is cleared only by power-on reset or by software.

Top module: `wdt_core`

## Requirements
- R1: When the watchdog is restarted or enabled, the warning flag (control bit 2) sets on the tick that brings the count to 2^(BASE+STEP*sel). Here sel is configuration bits [1:0], with codes 0 to 3. The defaults give 2^15, 2^18, 2^21 and 2^24.
- R2: The reset request `wd_rst_o` is a pulse one clock cycle wide. It comes GAP ticks (128 by default) after the warning flag sets, unless the watchdog is restarted or stopped first.
- R3: `irq_o` is high only while the warning flag is set and the interrupt enable (configuration bit 2) is 1.
- R4: A guarded control write with bit 0 set restarts the count from zero, so the next warning comes a full interval after that write. Control bit 0 always reads back as 0.
- R5: The count advances only on a `tick` while the run bit (control bit 1) is 1. With the run bit at 0, no warning flag and no reset request appear.
- R6: When the reset request fires, the block also sets the reset-seen flag (control bit 3) and clears the run bit, the warning flag, the count, the unlock state and the configuration register.
- R7: Control bits 0 to 2 are written only if, with no write to any address in between, the write follows a write of AAh and then 55h to address 0. It must also fall within WIN ticks (3 by default) after the 55h write. Otherwise those bits keep their values.
- R8: `prio_o` follows configuration bit 3: 1 marks the warning interrupt as high priority, 0 as low.
- R9: A guarded control write with bit 2 at 0 clears the warning flag, and `irq_o` drops with it.
- R10: A control write with bit 3 at 0 clears the reset-seen flag without unlocking. Writing 1 there has no effect. Power-on reset clears every bit, and all outputs come out of it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Instruction-cycle enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 unlock, 1 control, 2 configuration |
| wr_data | input | 8 | Write data |
| ctrl_o | output | 4 | Control readback {reset_seen, warn_flag, run, 0} |
| irq_o | output | 1 | Warning interrupt request |
| prio_o | output | 1 | Warning interrupt priority, 1 = high |
| wd_rst_o | output | 1 | System reset request, one-cycle pulse |

## Verification
All state is registered, so a write appears on `ctrl_o`, `irq_o` and `prio_o` one clock after the edge that captures it. With `tick` held high, the warning flag appears exactly the interval after the restarting edge, and the reset pulse GAP cycles after that. The bench drives on falling edges and counts falling edges from the write that starts the count. It checks the first cycle each event is seen, not whether the event happened at some point. For the unlock window it places the guarded write one cycle inside and one cycle outside the WIN-tick limit, and it reads the run bit back after each attempt.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int ADDR_W = 2;
   localparam int DATA_W = 8;

   localparam logic [ADDR_W-1:0] A_UNLOCK = 2'd0;
   localparam logic [ADDR_W-1:0] A_CTRL   = 2'd1;
   localparam logic [ADDR_W-1:0] A_CFG    = 2'd2;

   localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
   localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;

   // control register bit positions
   localparam int CB_KICK = 0;
   localparam int CB_RUN  = 1;
   localparam int CB_FLAG = 2;
   localparam int CB_SEEN = 3;

   // configuration register bit positions
   localparam int FB_SEL  = 0;   // two bits
   localparam int FB_IEN  = 2;
   localparam int FB_PRIO = 3;

   localparam int N_SEL = 4;

   typedef enum logic [1:0] {
      UL_IDLE  = 2'd0,
      UL_ARMED = 2'd1,
      UL_OPEN  = 2'd2
   } ul_state_e;

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
   import wdt_pkg::*;
#(
   parameter int WIN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              open_o
);
   localparam int WIN_W = $clog2(WIN + 1);

   ul_state_e        state_q;
   logic [WIN_W-1:0] win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= UL_IDLE;
         win_q   <= '0;
      end else if (clr) begin
         state_q <= UL_IDLE;
         win_q   <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_UNLOCK) begin
            if (wr_data == KEY_FIRST) begin
               state_q <= UL_ARMED;
            end else if (state_q == UL_ARMED && wr_data == KEY_SECOND) begin
               state_q <= UL_OPEN;
               win_q   <= WIN_W'(WIN);
            end else begin
               state_q <= UL_IDLE;
            end
         end else begin
            // any other write consumes or breaks the sequence
            state_q <= UL_IDLE;
         end
      end else if (state_q == UL_OPEN && tick) begin
         if (win_q == WIN_W'(1)) state_q <= UL_IDLE;
         win_q <= win_q - WIN_W'(1);
      end
   end

   assign open_o = (state_q == UL_OPEN);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
   import wdt_pkg::*;
#(
   parameter int BASE  = 15,
   parameter int STEP  = 3,
   parameter int GAP   = 128,
   parameter int CNT_W = 26
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick,
   input  logic       kick,
   input  logic [1:0] sel,
   output logic       hit_irq,
   output logic       hit_rst
);
   logic [CNT_W-1:0] thr_irq [N_SEL];
   logic [CNT_W-1:0] thr_rst [N_SEL];
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_n;
   logic             adv;

   for (genvar g = 0; g < N_SEL; g++) begin : g_thr
      assign thr_irq[g] = CNT_W'(1) << (BASE + g * STEP);
      assign thr_rst[g] = thr_irq[g] + CNT_W'(GAP);
   end

   assign adv     = run & tick & ~kick;
   assign cnt_n   = cnt_q + CNT_W'(1);
   assign hit_irq = adv && (cnt_n == thr_irq[sel]);
   assign hit_rst = adv && (cnt_n == thr_rst[sel]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (kick || hit_rst)  cnt_q <= '0;
      else if (adv)              cnt_q <= cnt_n;
   end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
   import wdt_pkg::*;
#(
   parameter int BASE = 15,
   parameter int STEP = 3,
   parameter int GAP  = 128,
   parameter int WIN  = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [7:0]  wr_data,
   output logic [3:0]  ctrl_o,
   output logic        irq_o,
   output logic        prio_o,
   output logic        wd_rst_o
);
   localparam int MAX_EXP = BASE + (N_SEL - 1) * STEP;
   localparam int CNT_W   = MAX_EXP + 2;

   if (BASE < 1 || STEP < 1) begin : g_bad_shift
      $error("wdt_core: BASE and STEP must be at least 1");
   end
   if (GAP < 1 || GAP > 2 ** MAX_EXP) begin : g_bad_gap
      $error("wdt_core: GAP out of range");
   end
   if (WIN < 1) begin : g_bad_win
      $error("wdt_core: WIN must be at least 1");
   end

   logic       unl_open;
   logic       ctrl_wr;
   logic       cfg_wr;
   logic       prot_wr;
   logic       kick;
   logic       rst_hit;
   logic       irq_hit;
   logic       run_q;
   logic       flag_q;
   logic       seen_q;
   logic       ien_q;
   logic       prio_q;
   logic       pulse_q;
   logic [1:0] sel_q;

   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
   assign cfg_wr  = wr_en && (wr_addr == A_CFG);
   assign prot_wr = ctrl_wr && unl_open;
   assign kick    = prot_wr && wr_data[CB_KICK];

   wdt_unlock #(.WIN(WIN)) u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (rst_hit),
      .tick    (tick),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .open_o  (unl_open)
   );

   wdt_counter #(
      .BASE (BASE),
      .STEP (STEP),
      .GAP  (GAP),
      .CNT_W(CNT_W)
   ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .tick    (tick),
      .kick    (kick),
      .sel     (sel_q),
      .hit_irq (irq_hit),
      .hit_rst (rst_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         flag_q  <= 1'b0;
         seen_q  <= 1'b0;
         sel_q   <= 2'd0;
         ien_q   <= 1'b0;
         prio_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else if (rst_hit) begin
         pulse_q <= 1'b1;
         seen_q  <= 1'b1;
         run_q   <= 1'b0;
         flag_q  <= 1'b0;
         sel_q   <= 2'd0;
         ien_q   <= 1'b0;
         prio_q  <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (cfg_wr) begin
            sel_q  <= wr_data[FB_SEL +: 2];
            ien_q  <= wr_data[FB_IEN];
            prio_q <= wr_data[FB_PRIO];
         end
         if (ctrl_wr && !wr_data[CB_SEEN]) seen_q <= 1'b0;
         if (prot_wr) begin
            run_q  <= wr_data[CB_RUN];
            flag_q <= wr_data[CB_FLAG];
         end
         if (irq_hit) flag_q <= 1'b1;
      end
   end

   assign ctrl_o   = {seen_q, flag_q, run_q, 1'b0};
   assign irq_o    = flag_q & ien_q;
   assign prio_o   = prio_q;
   assign wd_rst_o = pulse_q;

endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk
   import wdt_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] wr_addr,
   input logic [3:0] ctrl_o,
   input logic       irq_o,
   input logic       wd_rst_o,
   input logic       win_open,
   input logic       rst_hit
);
   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst_o |=> !wd_rst_o);                                             // R2

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ctrl_o[CB_FLAG]);                                          // R3

   AST_STOPPED_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_o[CB_RUN] |=> !wd_rst_o);                                      // R5

   AST_RST_MARKS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst_o |-> (ctrl_o[CB_SEEN] && !ctrl_o[CB_RUN] && !ctrl_o[CB_FLAG])); // R6

   AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CTRL && !win_open && !rst_hit)
      |=> $stable(ctrl_o[CB_RUN]));                                        // R7

   AST_FIRE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
      rst_hit |=> wd_rst_o);                                               // R2

endmodule

bind wdt_core wdt_core_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .ctrl_o   (ctrl_o),
   .irq_o    (irq_o),
   .wd_rst_o (wd_rst_o),
   .win_open (unl_open),
   .rst_hit  (rst_hit)
);

// File: tb/wdt_core_tb.sv
module wdt_core_tb;
   localparam int BASE = 4;
   localparam int STEP = 1;
   localparam int GAP  = 128;
   localparam int WIN  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [3:0] ctrl_o;
   logic       irq_o;
   logic       prio_o;
   logic       wd_rst_o;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;   // 50 MHz

   wdt_core #(.BASE(BASE), .STEP(STEP), .GAP(GAP), .WIN(WIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_o(ctrl_o),
      .irq_o(irq_o), .prio_o(prio_o), .wd_rst_o(wd_rst_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic guarded(input logic [7:0] d);
      wr(2'd0, 8'hAA);
      wr(2'd0, 8'h55);
      wr(2'd1, d);
   endtask

   // control data: bit0 restart, bit1 run, bit2 flag, bit3 keep reset-seen
   task automatic t_interval(input int sel, input bit ien, input bit prio);
      int p, first_flag, first_rst, rst_cycles, irq_at_flag;
      p = 1 << (BASE + sel * STEP);
      first_flag = -1; first_rst = -1; rst_cycles = 0; irq_at_flag = 0;
      wr(2'd2, {4'b0, prio, ien, sel[1:0]});
      guarded(8'h0B);
      chk(ctrl_o[0] == 1'b0, "R4 restart bit reads 0", ctrl_o[0], 0);
      for (int k = 1; k <= p + GAP + 4; k++) begin
         @(negedge clk);
         if (first_flag < 0 && ctrl_o[2]) begin
            first_flag = k;
            irq_at_flag = irq_o;
         end
         if (wd_rst_o) begin
            if (first_rst < 0) first_rst = k;
            rst_cycles++;
         end
      end
      chk(first_flag == p, "R1 warning point", first_flag, p);
      chk(irq_at_flag == int'(ien), "R3 irq gated by enable", irq_at_flag, int'(ien));
      chk(first_rst == p + GAP, "R2 reset after gap", first_rst, p + GAP);
      chk(rst_cycles == 1, "R2 pulse width", rst_cycles, 1);
      chk(ctrl_o == 4'b1000, "R6 state after watchdog reset", ctrl_o, 8);
      chk(prio_o == 1'b0 && irq_o == 1'b0, "R6 config cleared", prio_o, 0);
   endtask

   task automatic t_restart;
      int p, first_flag;
      p = 1 << BASE;
      first_flag = -1;
      wr(2'd2, 8'h04);
      guarded(8'h0B);
      idle(p - 4);   // guarded restart lands on the edge before expiry
      chk(ctrl_o[2] == 1'b0, "R4 no flag before restart", ctrl_o[2], 0);
      guarded(8'h0B);
      chk(ctrl_o[2] == 1'b0, "R4 no flag at old expiry", ctrl_o[2], 0);
      for (int k = 1; k <= p + 2; k++) begin
         @(negedge clk);
         if (first_flag < 0 && ctrl_o[2]) first_flag = k;
      end
      chk(first_flag == p, "R4 full interval after restart", first_flag, p);
      chk(irq_o == 1'b1, "R3 irq with enable", irq_o, 1);
      guarded(8'h0A);   // clear flag, keep running
      chk(ctrl_o[2] == 1'b0 && irq_o == 1'b0, "R9 flag cleared", ctrl_o[2], 0);
      guarded(8'h08);   // stop
      chk(ctrl_o[1] == 1'b0, "R5 stopped", ctrl_o[1], 0);
   endtask

   task automatic t_unlock;
      wr(2'd2, 8'h07);     // sel 3, enable irq
      guarded(8'h0B);
      chk(ctrl_o[1] == 1'b1, "R7 guarded write starts", ctrl_o[1], 1);
      wr(2'd1, 8'h08);
      chk(ctrl_o[1] == 1'b1, "R7 locked write ignored", ctrl_o[1], 1);
      wr(2'd0, 8'hAA); wr(2'd0, 8'h12); wr(2'd1, 8'h08);
      chk(ctrl_o[1] == 1'b1, "R7 wrong second key", ctrl_o[1], 1);
      wr(2'd0, 8'hAA); wr(2'd2, 8'h07); wr(2'd0, 8'h55); wr(2'd1, 8'h08);
      chk(ctrl_o[1] == 1'b1, "R7 write between keys", ctrl_o[1], 1);
      wr(2'd0, 8'hAA); wr(2'd0, 8'h55); idle(3); wr(2'd1, 8'h08);
      chk(ctrl_o[1] == 1'b1, "R7 window expired", ctrl_o[1], 1);
      wr(2'd0, 8'hAA); wr(2'd0, 8'h55); idle(2); wr(2'd1, 8'h08);
      chk(ctrl_o[1] == 1'b0, "R7 last tick of window", ctrl_o[1], 0);
   endtask

   task automatic t_stopped;
      int flags, rsts;
      flags = 0; rsts = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (ctrl_o[2]) flags++;
         if (wd_rst_o) rsts++;
      end
      chk(flags == 0, "R5 no flag when stopped", flags, 0);
      chk(rsts == 0, "R5 no reset when stopped", rsts, 0);
   endtask

   task automatic t_prio_seen;
      wr(2'd2, 8'h08);
      chk(prio_o == 1'b1, "R8 priority high", prio_o, 1);
      wr(2'd2, 8'h00);
      chk(prio_o == 1'b0, "R8 priority low", prio_o, 0);
      chk(ctrl_o[3] == 1'b1, "R10 seen still set", ctrl_o[3], 1);
      wr(2'd1, 8'h08);
      chk(ctrl_o[3] == 1'b1, "R10 writing 1 keeps seen", ctrl_o[3], 1);
      wr(2'd1, 8'h00);
      chk(ctrl_o == 4'b0000, "R10 seen cleared without unlock", ctrl_o, 0);
   endtask

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      chk(ctrl_o == 4'b0000 && irq_o == 1'b0 && prio_o == 1'b0 && wd_rst_o == 1'b0,
          "R10 reset state", ctrl_o, 0);
      rst_n = 1'b1;
      idle(2);
      chk(ctrl_o == 4'b0000 && wd_rst_o == 1'b0, "R10 after release", ctrl_o, 0);
      t_interval(0, 1'b1, 1'b0);
      t_interval(1, 1'b1, 1'b0);
      t_interval(2, 1'b1, 1'b1);
      t_interval(3, 1'b1, 1'b0);
      t_interval(0, 1'b0, 1'b0);
      t_restart;
      t_unlock;
      t_stopped;
      t_prio_seen;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule